// File: doc/BRIEF.md
# Phase-Accumulator Clock Synthesizer

This block derives a slower clock from a fast source clock. A phase accumulator of `PH_W` bits adds a programmed increment on every source edge. Its top bit is the synthesized clock, so the average output frequency is `phase * f_src / 2^PH_W`. A power-of-two increment turns the accumulator into an exact, jitter-free divider. Other increments give the right average frequency, with one source period of cycle-to-cycle jitter. An increment of zero passes the source clock straight through. The default is a 14-bit accumulator; a 6-bit build is also supported.

A mode bit switches to a plain integer divider instead. Divide value `D` gives a period of `D+1` source cycles with close to 50% duty. `D = 0` passes the source through. The source is picked from three clock inputs and a pre-divided PLL clock. Beside the clock, the block gives a strobe that is high for one source cycle at each rising edge of the output. This lets downstream logic on the source clock use it as a clock enable. Configuration is a simple write port that runs on the selected source clock.

Top module: `phase_clk_synth`

## Requirements
- R1: After reset the increment is 0, the mode is accumulator (mode bit 0), the divide value is 0 and the accumulator is clear. So `clk_out` follows the selected source and `stb_out` is held high.
- R2: In accumulator mode with an increment of 0, `clk_out` equals the selected source clock and `stb_out` stays high.
- R3: An increment with only its top bit set (0x2000 at 14 bits, 0x20 at 6 bits) gives half the source rate: one cycle high, one cycle low.
- R4: An increment of `2^(PH_W-k)` gives an exact period of `2^k` source cycles, with `2^(k-1)` cycles high.
- R5: For any increment P from 1 to `2^(PH_W-1)`, the number of `clk_out` rising edges in W source cycles is within 1 of `P*W/2^PH_W`.
- R6: When not in bypass, `stb_out` is high in exactly those source cycles in which `clk_out` has just gone from low to high.
- R7: A newly written increment is added from the next source edge on, and the accumulator is not cleared by that write.
- R8: A write that changes the mode bit clears the accumulator and the divider counter on that edge. A write of the same mode value clears nothing.
- R9: In divider mode with `D >= 1`, `clk_out` has a period of `D+1` source cycles and is high for `floor((D+2)/2)` of them. `stb_out` pulses once per period, in the first high cycle.
- R10: In divider mode with `D = 0`, `clk_out` equals the selected source clock and `stb_out` stays high.
- R11: `src_sel` values 0, 1, 2 and 3 pick `clk_src0`, `clk_src1`, `clk_src2` and `clk_pll_div` as the source.
- R12: Write address 0 loads the increment (low `PH_W` data bits), address 1 loads the mode bit (data bit 0: 0 = accumulator, 1 = divider), and address 2 loads the divide value (low `DIV_W` bits). A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src0 | input | 1 | Source clock candidate 0 |
| clk_src1 | input | 1 | Source clock candidate 1 |
| clk_src2 | input | 1 | Source clock candidate 2 |
| clk_pll_div | input | 1 | Pre-divided PLL clock, source candidate 3 |
| src_sel | input | 2 | Source clock select |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable, sampled on the selected source clock |
| cfg_addr | input | 2 | Configuration write address |
| cfg_wdata | input | CFG_W | Configuration write data |
| clk_out | output | 1 | Synthesized clock |
| stb_out | output | 1 | One-source-cycle strobe at each rising edge of `clk_out` |

## Verification
The bench builds two instances from the same clocks. The first uses the default `PH_W = 14`, `DIV_W = 8` and `CFG_W = 16`. With it the bench checks the 696 example, random increments up to half scale, exact power-of-two periods up to divide-by-64, and divide values up to 40 on the 8-bit divider. The second instance uses `PH_W = 6`, which makes the coarse 6-bit increments 0x20 and 0x08 reachable and shows that the rate formula scales with the accumulator width. Both build on four source clocks of different periods, so every position of the source selector gives a distinct output rate.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;

  typedef enum logic {
    MODE_ACC = 1'b0,
    MODE_DIV = 1'b1
  } synth_mode_e;

  localparam logic [1:0] ADDR_PHASE = 2'd0;
  localparam logic [1:0] ADDR_MODE  = 2'd1;
  localparam logic [1:0] ADDR_DIVV  = 2'd2;

  // A rising edge of a registered level, seen from its old and new value.
  function automatic logic level_rise(input logic old_v, input logic new_v);
    return new_v && !old_v;
  endfunction

endpackage

// File: rtl/clk_src_mux.sv
module clk_src_mux #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_SRC-1:0] src_vec,
  input  logic [SEL_W-1:0]   sel,
  output logic               clk_o
);

  logic [NUM_SRC-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_leg
      assign hit[gi] = src_vec[gi] && (sel == SEL_W'(gi));
    end
  endgenerate

  assign clk_o = |hit;

endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
  import clk_synth_pkg::*;
#(
  parameter int PH_W  = 14,
  parameter int DIV_W = 8,
  parameter int CFG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [CFG_W-1:0]  wdata,
  output logic [PH_W-1:0]   phase_q,
  output synth_mode_e       mode_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              clr_o
);

  synth_mode_e mode_wr;
  assign mode_wr = synth_mode_e'(wdata[0]);

  // Mode change pulse: only a write that actually flips the mode bit.
  assign clr_o = we && (addr == ADDR_MODE) && (mode_wr != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      mode_q  <= MODE_ACC;
      div_q   <= '0;
    end else if (we) begin
      case (addr)
        ADDR_PHASE: phase_q <= wdata[PH_W-1:0];
        ADDR_MODE:  mode_q  <= mode_wr;
        ADDR_DIVV:  div_q   <= wdata[DIV_W-1:0];
        default:    ;
      endcase
    end
  end

  // R12
  cfg_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd3) |=> ($stable(phase_q) && $stable(mode_q) && $stable(div_q)));

  // R7
  phase_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_PHASE) |=> (phase_q == $past(wdata[PH_W-1:0])));

endmodule

// File: rtl/dco_accum.sv
module dco_accum
  import clk_synth_pkg::*;
#(
  parameter int PH_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [PH_W-1:0] phase,
  output logic            msb_o,
  output logic            stb_o
);

  localparam int TOP = PH_W - 1;

  logic [PH_W-1:0] acc_q;
  logic [PH_W-1:0] acc_nxt;
  logic            stb_q;

  assign acc_nxt = clr ? '0 : (acc_q + phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      stb_q <= 1'b0;
    end else begin
      acc_q <= acc_nxt;
      stb_q <= level_rise(acc_q[TOP], acc_nxt[TOP]);
    end
  end

  assign msb_o = acc_q[TOP];
  assign stb_o = stb_q;

  // R8
  acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));

  // R6
  dco_stb_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (acc_q[TOP] && !$past(acc_q[TOP])));

endmodule

// File: rtl/int_div_gen.sv
module int_div_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_val,
  output logic             clk_o,
  output logic             stb_o
);

  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic [CW-1:0]    hi_len;
  logic             hi_q;
  logic             stb_q;

  // High for ceil((D+1)/2) of the D+1 cycles of one period.
  assign hi_len  = ({1'b0, div_val} + CW'(2)) >> 1;
  assign cnt_nxt = (clr || (cnt_q >= div_val)) ? '0 : (cnt_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      hi_q  <= ({1'b0, cnt_nxt} < hi_len);
      stb_q <= (cnt_nxt == '0);
    end
  end

  assign clk_o = hi_q;
  assign stb_o = stb_q;

  // R9
  div_stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && !clr && div_val != '0) |=> !stb_q);

  // R8
  div_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && stb_q));

endmodule

// File: rtl/phase_clk_synth.sv
module phase_clk_synth
  import clk_synth_pkg::*;
#(
  parameter int PH_W  = 14,
  parameter int DIV_W = 8,
  parameter int CFG_W = 16
) (
  input  logic             clk_src0,
  input  logic             clk_src1,
  input  logic             clk_src2,
  input  logic             clk_pll_div,
  input  logic [1:0]       src_sel,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             clk_out,
  output logic             stb_out
);

  localparam int NUM_SRC = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);

  logic             src_clk;
  logic [PH_W-1:0]  phase;
  synth_mode_e      mode;
  logic [DIV_W-1:0] div_val;
  logic             mode_clr;
  logic             acc_clk, acc_stb;
  logic             div_clk, div_stb;
  logic             gen_clk, gen_stb;
  logic             bypass;

  clk_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_src_mux (
    .src_vec ({clk_pll_div, clk_src2, clk_src1, clk_src0}),
    .sel     (src_sel),
    .clk_o   (src_clk)
  );

  synth_cfg_regs #(.PH_W(PH_W), .DIV_W(DIV_W), .CFG_W(CFG_W)) u_regs (
    .clk     (src_clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .phase_q (phase),
    .mode_q  (mode),
    .div_q   (div_val),
    .clr_o   (mode_clr)
  );

  dco_accum #(.PH_W(PH_W)) u_acc (
    .clk   (src_clk),
    .rst_n (rst_n),
    .clr   (mode_clr),
    .phase (phase),
    .msb_o (acc_clk),
    .stb_o (acc_stb)
  );

  int_div_gen #(.DIV_W(DIV_W)) u_div (
    .clk     (src_clk),
    .rst_n   (rst_n),
    .clr     (mode_clr),
    .div_val (div_val),
    .clk_o   (div_clk),
    .stb_o   (div_stb)
  );

  assign bypass  = (mode == MODE_ACC) ? (phase == '0) : (div_val == '0);
  assign gen_clk = (mode == MODE_ACC) ? acc_clk : div_clk;
  assign gen_stb = (mode == MODE_ACC) ? acc_stb : div_stb;

  assign clk_out = bypass ? src_clk : gen_clk;
  assign stb_out = bypass ? 1'b1    : gen_stb;

  // R6
  stb_high_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    (!bypass && stb_out) |-> clk_out);

endmodule

// File: tb/phase_clk_synth_tb.sv
module phase_clk_synth_tb_top;

  localparam int PH_W  = 14;
  localparam int DIV_W = 8;
  localparam int CFG_W = 16;

  logic clk_src0 = 1'b0;
  logic clk_src1 = 1'b0;
  logic clk_src2 = 1'b0;
  logic clk_pll  = 1'b0;
  always #4 clk_src0 = ~clk_src0;
  always #5 clk_src1 = ~clk_src1;
  always #6 clk_src2 = ~clk_src2;
  always #8 clk_pll  = ~clk_pll;

  logic             rst_n = 1'b0;
  logic [1:0]       src_sel = 2'd0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = 2'd0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic             cfg6_we = 1'b0;
  logic [1:0]       cfg6_addr = 2'd0;
  logic [CFG_W-1:0] cfg6_wdata = '0;
  wire              clk_out, stb_out, clk6_out, stb6_out;

  phase_clk_synth #(.PH_W(PH_W), .DIV_W(DIV_W), .CFG_W(CFG_W)) dut_i (
    .clk_src0(clk_src0), .clk_src1(clk_src1), .clk_src2(clk_src2), .clk_pll_div(clk_pll),
    .src_sel(src_sel), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .clk_out(clk_out), .stb_out(stb_out)
  );

  phase_clk_synth #(.PH_W(6), .DIV_W(DIV_W), .CFG_W(CFG_W)) dut6_i (
    .clk_src0(clk_src0), .clk_src1(clk_src1), .clk_src2(clk_src2), .clk_pll_div(clk_pll),
    .src_sel(src_sel), .rst_n(rst_n), .cfg_we(cfg6_we), .cfg_addr(cfg6_addr),
    .cfg_wdata(cfg6_wdata), .clk_out(clk6_out), .stb_out(stb6_out)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int unsigned edge_cnt  = 0;
  int unsigned edge6_cnt = 0;
  always @(posedge clk_out)  edge_cnt++;
  always @(posedge clk6_out) edge6_cnt++;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int unsigned d);
    @(negedge clk_src0);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CFG_W'(d);
    @(negedge clk_src0);
    cfg_we = 1'b0;
  endtask

  task automatic wr6(input logic [1:0] a, input int unsigned d);
    @(negedge clk_src0);
    cfg6_we = 1'b1; cfg6_addr = a; cfg6_wdata = CFG_W'(d);
    @(negedge clk_src0);
    cfg6_we = 1'b0;
  endtask

  // Samples clk_out once per source cycle away from the edge.
  task automatic measure(input int w, output int rises, output int pmin, output int pmax,
                         output int hmin, output int hmax, output int sbad);
    int last, hcnt;
    bit prev, cur, track;
    rises = 0; pmin = 1 << 30; pmax = 0; hmin = 1 << 30; hmax = 0; sbad = 0;
    last = -1; hcnt = 0; track = 1'b0;
    @(negedge clk_src0);
    prev = clk_out;
    for (int i = 0; i < w; i++) begin
      @(negedge clk_src0);
      cur = clk_out;
      if (stb_out != (cur && !prev)) sbad++;
      if (cur && !prev) begin
        rises++;
        if (last >= 0) begin
          if (i - last < pmin) pmin = i - last;
          if (i - last > pmax) pmax = i - last;
        end
        last = i; hcnt = 1; track = 1'b1;
      end else if (cur && track) begin
        hcnt++;
      end else if (!cur && prev && track) begin
        if (hcnt < hmin) hmin = hcnt;
        if (hcnt > hmax) hmax = hcnt;
        track = 1'b0;
      end
      prev = cur;
    end
  endtask

  task automatic bypass_probe(output int errs);
    errs = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_src0); #1;
      if (clk_out !== 1'b1 || stb_out !== 1'b1) errs++;
      @(negedge clk_src0); #1;
      if (clk_out !== 1'b0 || stb_out !== 1'b1) errs++;
    end
  endtask

  function automatic int exp_rises(input int unsigned ph, input int w);
    return int'((longint'(ph) * w) >> PH_W);
  endfunction

  function automatic int absdiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic run_pow2(input int k, input string req);
    int r, p0, p1, h0, h1, sb;
    wr(2'd0, 1 << (PH_W - k));
    repeat (4) @(negedge clk_src0);
    measure(256, r, p0, p1, h0, h1, sb);
    check(p0 == (1 << k) && p1 == (1 << k), req, $sformatf("period k=%0d", k), p1, 1 << k);
    check(h0 == (1 << (k - 1)) && h1 == (1 << (k - 1)), req, $sformatf("high k=%0d", k),
          h1, 1 << (k - 1));
    check(sb == 0, "R6", $sformatf("strobe mismatches k=%0d", k), sb, 0);
  endtask

  initial begin : watchdog
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all-reqs: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int r, p0, p1, h0, h1, sb, errs, e;
    int unsigned c0, c1, ph;
    int unsigned per [4];
    logic [PH_W-1:0] m_acc, m_prev, m_ph;
    per[0] = 8; per[1] = 10; per[2] = 12; per[3] = 16;
    void'($urandom(32'd4711));

    // R1 reset state
    repeat (3) @(negedge clk_src0);
    rst_n = 1'b1;
    bypass_probe(errs);
    check(errs == 0, "R1", "reset-state follows source", errs, 0);

    // R2 bypass after a nonzero increment
    wr(2'd0, 32'h1000);
    wr(2'd0, 32'h0000);
    bypass_probe(errs);
    check(errs == 0, "R2", "zero increment bypass", errs, 0);

    // R3 half rate
    wr(2'd0, 32'h2000);
    repeat (4) @(negedge clk_src0);
    measure(64, r, p0, p1, h0, h1, sb);
    check(p0 == 2 && p1 == 2 && h0 == 1 && h1 == 1, "R3", "half-rate period", p1, 2);
    check(r == 32, "R3", "half-rate edges", r, 32);
    check(sb == 0, "R6", "half-rate strobe", sb, 0);

    // R4 power-of-two divisions
    for (int k = 2; k <= 6; k++) run_pow2(k, "R4");

    // R4 / R3 on the 6-bit build
    wr6(2'd0, 32'h20);
    repeat (4) @(negedge clk_src0);
    c0 = edge6_cnt; #4000; c1 = edge6_cnt;
    check(absdiff(int'(c1 - c0), 250) <= 1, "R3", "6-bit half rate edges", c1 - c0, 250);
    wr6(2'd0, 32'h08);
    repeat (4) @(negedge clk_src0);
    c0 = edge6_cnt; #4000; c1 = edge6_cnt;
    check(absdiff(int'(c1 - c0), 62) <= 1, "R4", "6-bit divide-by-8 edges", c1 - c0, 62);

    // R12 unmapped address
    wr(2'd0, 32'h1000);
    wr(2'd3, 32'h0000);
    repeat (2) @(negedge clk_src0);
    measure(64, r, p0, p1, h0, h1, sb);
    check(p0 == 4 && p1 == 4 && r == 16, "R12", "addr 3 write ignored", p1, 4);

    // R5 directed example then random increments
    wr(2'd0, 696);
    measure(2048, r, p0, p1, h0, h1, sb);
    check(absdiff(r, exp_rises(696, 2048)) <= 1, "R5", "increment 696", r, exp_rises(696, 2048));
    check(sb == 0, "R6", "increment 696 strobe", sb, 0);
    for (int n = 0; n < 6; n++) begin
      ph = $urandom_range(1 << (PH_W - 1), 1);
      wr(2'd0, ph);
      measure(2048, r, p0, p1, h0, h1, sb);
      check(absdiff(r, exp_rises(ph, 2048)) <= 1, "R5", $sformatf("increment %0d", ph), r,
            exp_rises(ph, 2048));
      check(sb == 0, "R6", $sformatf("strobe inc %0d", ph), sb, 0);
    end

    // R7 / R8 cycle-exact model from a cleared accumulator
    wr(2'd0, 32'h0700);
    wr(2'd1, 32'h1);
    wr(2'd1, 32'h0);
    m_acc = '0; m_prev = '0; m_ph = PH_W'(32'h0700);
    errs = 0; e = 0;
    for (int i = 0; i < 48; i++) begin
      if (clk_out != m_acc[PH_W-1] ||
          stb_out != (m_acc[PH_W-1] && !m_prev[PH_W-1])) begin
        if (i <= 30) errs++; else e++;
      end
      if (i == 12) begin cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = CFG_W'(32'h1300); end
      if (i == 30) begin cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = CFG_W'(32'h0); end
      @(posedge clk_src0);
      m_prev = m_acc;
      m_acc  = m_acc + m_ph;
      if (i == 12) m_ph = PH_W'(32'h1300);
      @(negedge clk_src0);
      cfg_we = 1'b0;
    end
    check(errs == 0, "R7", "increment change keeps accumulator", errs, 0);
    check(e == 0, "R8", "same-mode write does not clear", e, 0);

    // R9 integer divider
    wr(2'd1, 32'h1);
    for (int n = 0; n < 6; n++) begin
      int d;
      d = (n < 2) ? n + 1 : int'($urandom_range(40, 3));
      wr(2'd2, d);
      repeat (2) @(negedge clk_src0);
      measure(256, r, p0, p1, h0, h1, sb);
      check(p0 == d + 1 && p1 == d + 1, "R9", $sformatf("divider period D=%0d", d), p1, d + 1);
      check(h0 == (d + 2) / 2 && h1 == (d + 2) / 2, "R9", $sformatf("divider high D=%0d", d),
            h1, (d + 2) / 2);
      check(sb == 0, "R9", $sformatf("divider strobe D=%0d", d), sb, 0);
    end

    // R10 divider bypass
    wr(2'd2, 32'h0);
    bypass_probe(errs);
    check(errs == 0, "R10", "divide value 0 bypass", errs, 0);

    // R11 source selection at divide-by-4
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h1000);
    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s);
      #200;
      c0 = edge_cnt; #4800; c1 = edge_cnt;
      check(absdiff(int'(c1 - c0), int'(4800 / (4 * per[s]))) <= 1, "R11",
            $sformatf("source %0d edges", s), c1 - c0, 4800 / (4 * per[s]));
    end
    src_sel = 2'd0;
    #100;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule